// File: doc/BRIEF.md
# Three-Phase Alternating Chopper Switch Controller

This block turns three asynchronous over-limit flags, one for each phase leg of an asymmetric half-bridge, into six registered gate-enable signals. Each leg has an upper and a lower switch. While a leg's measured current stays within its reference, both switches of the leg are held on, so the leg applies its normal voltage. When the current goes above the reference, the block turns off exactly one of the two switches, which lowers the voltage applied to that leg.

Each leg keeps its own select bit, and that bit flips on every new over-limit event. Successive chop intervals therefore fall on the upper and the lower device in turn, and the switching stress is shared between the two. A global enable forces every gate off without losing the select state. The asynchronous reset asserts at once and is released on a clock edge.

Top module: `chop_ctrl_top`

## Requirements
- R1: While reset is asserted and after it is released, all six gate outputs are 0 and every phase select bit is 0. The first over-limit event after reset therefore turns the upper switch off.
- R2: When `en` is low at a rising clock edge, all six gate outputs are 0 after that edge.
- R3: When `en` is high and a phase's synchronised over-limit flag is low, that phase's `hi_gate` and `lo_gate` bits are both 1.
- R4: When `en` is high and a phase's synchronised over-limit flag is high, exactly one of its two gates is 0. A select value of 1 gives upper off and lower on. A select value of 0 gives lower off and upper on.
- R5: A phase's select bit toggles on each rising edge of its synchronised over-limit flag that occurs while `en` is high. Consecutive over-limit events on a phase therefore chop the upper and the lower switch alternately.
- R6: While `en` is low, the select bits keep their values. A rising edge seen while `en` is low does not toggle a select bit and is not replayed when `en` returns.
- R7: Bit 0 of every vector port is phase A, bit 1 is phase B and bit 2 is phase C. An event on one phase never changes the select bit or the gates of another phase.
- R8: A change on `ovr_in` reaches the gates on the third rising clock edge after it is applied: two synchroniser stages plus one output register. It never reaches them earlier.
- R9: While `en` and a phase's synchronised flag both stay high, the gate pair of that phase holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Global gate enable, synchronous to `clk` |
| ovr_in | input | 3 | Per-phase over-limit flags (1 = current above reference), asynchronous |
| hi_gate | output | 3 | Per-phase upper switch on command (1 = on) |
| lo_gate | output | 3 | Per-phase lower switch on command (1 = on) |

## Verification
The assertions assume that `en` is synchronous to `clk`. The over-limit flags may change at any time, but the assertions only look at them after the synchroniser. The bench therefore changes `en` and `ovr_in` only at falling clock edges, and it holds every level for at least four cycles, so each change passes through both synchroniser stages and is seen as a clean edge. Disabled-period edges, simultaneous edges on all phases and a reset in the middle of operation are all applied within those limits.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_drive_t;

  localparam leg_drive_t LEG_OFF  = '{hi: 1'b0, lo: 1'b0};
  localparam leg_drive_t LEG_FULL = '{hi: 1'b1, lo: 1'b1};

  // Drive for one leg given enable, synchronised over-limit and select.
  function automatic leg_drive_t leg_drive(input logic enable,
                                           input logic over,
                                           input logic sel);
    leg_drive_t d;
    if (!enable) begin
      d = LEG_OFF;
    end else if (!over) begin
      d = LEG_FULL;
    end else begin
      d.hi = ~sel;
      d.lo = sel;
    end
    return d;
  endfunction

endpackage

// File: rtl/chop_rst_sync.sv
module chop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_core_n = chain_q[STAGES-1];

endmodule

// File: rtl/chop_in_sync.sv
module chop_in_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = async_in;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_d;
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/chop_leg.sv
module chop_leg
  import chop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ovr_s,
  output logic hi_gate,
  output logic lo_gate
);

  logic       prev_q;
  logic       sel_q;
  logic       sel_d;
  logic       sel_ce;
  logic       rise;
  leg_drive_t drv_q;
  leg_drive_t drv_d;

  // Next-state logic
  always_comb begin
    rise   = ovr_s & ~prev_q;
    sel_ce = rise & en;
    sel_d  = sel_q ^ sel_ce;
    drv_d  = leg_drive(en, ovr_s, sel_d);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= ovr_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (sel_ce) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= LEG_OFF;
    end else begin
      drv_q <= drv_d;
    end
  end

  assign hi_gate = drv_q.hi;
  assign lo_gate = drv_q.lo;

endmodule

// File: rtl/chop_ctrl_top.sv
module chop_ctrl_top #(
  parameter int PHASES      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PHASES-1:0] ovr_in,
  output logic [PHASES-1:0] hi_gate,
  output logic [PHASES-1:0] lo_gate
);

  logic              rst_core_n;
  logic [PHASES-1:0] ovr_sync;

  chop_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  chop_in_sync #(
    .WIDTH  (PHASES),
    .STAGES (SYNC_STAGES)
  ) u_in_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in (ovr_in),
    .sync_out (ovr_sync)
  );

  genvar p;
  generate
    for (p = 0; p < PHASES; p++) begin : g_leg
      chop_leg u_leg (
        .clk     (clk),
        .rst_n   (rst_core_n),
        .en      (en),
        .ovr_s   (ovr_sync[p]),
        .hi_gate (hi_gate[p]),
        .lo_gate (lo_gate[p])
      );
    end
  endgenerate

endmodule

// File: rtl/chop_ctrl_checker.sv
module chop_ctrl_checker #(
  parameter int PHASES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [PHASES-1:0] ovr_s,
  input logic [PHASES-1:0] hi_gate,
  input logic [PHASES-1:0] lo_gate
);

  AST_DISABLED_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (hi_gate == '0 && lo_gate == '0)); // R2

  genvar p;
  generate
    for (p = 0; p < PHASES; p++) begin : g_chk
      AST_IN_RANGE_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ovr_s[p]) |=> (hi_gate[p] && lo_gate[p])); // R3

      AST_ONE_SWITCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ovr_s[p]) |=> (hi_gate[p] ^ lo_gate[p])); // R4

      AST_CHOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ovr_s[p] && $past(en) && $past(ovr_s[p]))
          |=> $stable({hi_gate[p], lo_gate[p]})); // R9
    end
  endgenerate

endmodule

bind chop_ctrl_top chop_ctrl_checker #(
  .PHASES (PHASES)
) u_chop_ctrl_checker (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .en      (en),
  .ovr_s   (ovr_sync),
  .hi_gate (hi_gate),
  .lo_gate (lo_gate)
);

// File: tb/test_chop_ctrl_top.sv
module test_chop_ctrl_top;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic [2:0] ovr_in;
  logic [2:0] hi_gate;
  logic [2:0] lo_gate;

  int n_vec;
  int n_bad;
  bit done;

  chop_ctrl_top i_chop_ctrl_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .ovr_in  (ovr_in),
    .hi_gate (hi_gate),
    .lo_gate (lo_gate)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {en, ovr[2:0], exp_hi[2:0], exp_lo[2:0]}; bit0 = A, bit1 = B, bit2 = C
  localparam int NV = 13;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 3'b000, 3'b000, 3'b000}, // R2 disabled
    {1'b1, 3'b000, 3'b111, 3'b111}, // R3 in range
    {1'b1, 3'b001, 3'b110, 3'b111}, // R1 R5 first A event: upper off
    {1'b1, 3'b000, 3'b111, 3'b111}, // R3
    {1'b1, 3'b001, 3'b111, 3'b110}, // R5 second A event: lower off
    {1'b1, 3'b011, 3'b101, 3'b110}, // R7 B event, A untouched
    {1'b0, 3'b011, 3'b000, 3'b000}, // R2
    {1'b0, 3'b000, 3'b000, 3'b000}, // R2
    {1'b0, 3'b100, 3'b000, 3'b000}, // R6 C edge while disabled
    {1'b1, 3'b100, 3'b111, 3'b011}, // R6 C select still 0, no replay
    {1'b1, 3'b000, 3'b111, 3'b111}, // R3
    {1'b1, 3'b111, 3'b010, 3'b101}, // R4 R5 R7 all phases at once
    {1'b1, 3'b110, 3'b011, 3'b101}  // R7 A released, B C hold
  };

  task automatic check(input string req, input logic [2:0] ehi, input logic [2:0] elo);
    n_vec++;
    if (hi_gate !== ehi || lo_gate !== elo) begin
      n_bad++;
      $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", req, hi_gate, lo_gate, ehi, elo);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #40000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: hi=%b lo=%b expected run to end", hi_gate, lo_gate);
    finish_run();
  end

  initial begin
    n_vec = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    en    = 1'b0;
    ovr_in = 3'b000;
    repeat (3) @(negedge clk);
    check("R1 in reset", 3'b000, 3'b000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 3'b000, 3'b000);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      en     = VEC[i][9];
      ovr_in = VEC[i][8:6];
      repeat (4) @(negedge clk);
      check($sformatf("R2-7 vector %0d", i), VEC[i][5:3], VEC[i][2:0]);
    end

    // Reset mid-run: phase A select is 1 here, reset must clear it
    en = 1'b1;
    ovr_in = 3'b000;
    rst_n = 1'b0;
    #1;
    check("R1 async assert", 3'b000, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 after reset", 3'b111, 3'b111);

    // Latency: change at a falling edge, visible after the third rising edge
    ovr_in = 3'b001;
    repeat (2) @(negedge clk);
    check("R8 not before third edge", 3'b111, 3'b111);
    @(negedge clk);
    check("R8 R1 third edge, select cleared", 3'b110, 3'b111);
    repeat (5) @(negedge clk);
    check("R9 chop holds", 3'b110, 3'b111);

    // Enable drop takes effect after one edge, select kept
    en = 1'b0;
    @(negedge clk);
    check("R2 one clock", 3'b000, 3'b000);
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check("R6 select kept", 3'b110, 3'b111);

    finish_run();
  end

endmodule